// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block is the software-facing control side of a descriptor-driven DMA engine. It serves several channels behind one 32-bit word-wide register bus. Each channel sits in its own 8 KB address window. A channel holds its descriptor and buffer pointers, a configuration word, a command word, a stream-command word and an interrupt mask. It also keeps a raw interrupt vector and a masked copy of that vector, and it tracks whether the channel is in reset, stopped or running.

The block moves no data. Register writes become single-cycle request pulses toward the transfer engine: continue, load data descriptor, load context, and start. The engine reports back interrupt events, end-of-list, and a command-source code. Each channel drives one level interrupt line. Malformed command writes set sticky error flags in the status word instead of being dropped silently.

Top module: `dmareg_unit`

## Requirements
- R1: After reset, every register reads zero except status, which reads 0x101 (state reset, command source 1). Every request pulse and every interrupt line is low.
- R2: The pointer registers take full 32-bit writes and read back unchanged. The registers are current data descriptor 0x00, saved data pointer 0x58, saved buffer pointer 0x5C, group 0x60 and group-down 0x7C. The saved data pointer drives `desc_ptr` and the saved buffer pointer drives `buf_ptr`.
- R3: Address bits [ADDR_W-1:13] select the channel and bits [7:2] select the register. Bits [12:8] are ignored. A channel index at or above NUM_CH is not mapped: its reads return zero and its writes change nothing.
- R4: A write to configuration (0x84; bit 0 enable, bit 1 stop) sets the state to stopped when bit 1 is set, and to reset when bit 0 is clear. Reset takes precedence. Any other value leaves the state unchanged.
- R5: A stream-command write (0x9C) decodes only bits [9:0]. If bit 8 or bit 6 is set, a load-data pulse is issued. If, in addition, bit 5 is set, a start pulse is issued, the state becomes running and end-of-list clears, but only while configuration reads enable=1 and stop=0. Otherwise the start is ignored. If bit 9 is set, a load-context pulse is issued.
- R6: A stream-command write with any of bits [31:10] set raises sticky status bit 30. The low bits are still decoded.
- R7: A command write (0x80) with bit 0 set issues a continue pulse only while the state is running. A command write with any of bits [31:1] set raises sticky status bit 31. Any write to status (0x88) clears both sticky bits.
- R8: Status reads return a one-hot state in bits [2:0] (reset 1, stopped 2, running 4), end-of-list in bit 5, the command source in bits [8+SRC_W-1:8], and the sticky error bits in bits 30 and 31.
- R9: Raw interrupt bits (0x94) are set by engine events. A write to acknowledge (0x90) clears the bits that are 1 in the written value. An event in the same cycle as its acknowledge wins. Acknowledge always reads zero.
- R10: Masked interrupt (0x98) equals raw AND mask (0x8C). The interrupt line is high when any masked bit is set. Both update on the clock edge after the event, mask write or acknowledge.
- R11: The end-of-list flag is set by an engine end-of-list pulse and cleared by an accepted start.
- R12: The command-source field loads from the engine source input only on a cycle with the source-valid strobe.
- R13: A read returns its data on `bus_rdata` with `bus_rvalid` high on the cycle after `bus_rd`. Request pulses are high for exactly the cycle after the write that caused them.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| eng_intr_set | input | NUM_CH*INTR_W | Per-channel interrupt events |
| eng_eol | input | NUM_CH | Per-channel end-of-list pulse |
| eng_src_vld | input | NUM_CH | Per-channel source-valid strobe |
| eng_src | input | NUM_CH*SRC_W | Per-channel command source code |
| irq | output | NUM_CH | Level interrupt per channel |
| cont_req | output | NUM_CH | Continue request pulse |
| load_data_req | output | NUM_CH | Data descriptor load pulse |
| load_ctx_req | output | NUM_CH | Context load pulse |
| start_req | output | NUM_CH | Start pulse |
| desc_ptr | output | NUM_CH*32 | Saved data pointer per channel |
| buf_ptr | output | NUM_CH*32 | Saved buffer pointer per channel |

## Verification
The bench builds the block with NUM_CH=3 and ADDR_W=15. The two-bit channel field therefore has one unused code, 3, and the bench uses it to show that unmapped windows read zero and absorb writes. Three live channels let the bench confirm that writes and interrupts in one window never reach a neighbour. INTR_W=4 and SRC_W=8 keep the default layout, so the status field positions are the ones stated in the requirements.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } ch_state_e;

  // register word indices (byte offset / 4)
  localparam logic [5:0] RI_DATA   = 6'h00;
  localparam logic [5:0] RI_SAVED  = 6'h16;
  localparam logic [5:0] RI_SBUF   = 6'h17;
  localparam logic [5:0] RI_GROUP  = 6'h18;
  localparam logic [5:0] RI_GDOWN  = 6'h1F;
  localparam logic [5:0] RI_CMD    = 6'h20;
  localparam logic [5:0] RI_CFG    = 6'h21;
  localparam logic [5:0] RI_STAT   = 6'h22;
  localparam logic [5:0] RI_MASK   = 6'h23;
  localparam logic [5:0] RI_ACK    = 6'h24;
  localparam logic [5:0] RI_RAW    = 6'h25;
  localparam logic [5:0] RI_MASKED = 6'h26;
  localparam logic [5:0] RI_STREAM = 6'h27;

  // stream-command bit groups
  localparam logic [9:0] SC_LOAD_D = 10'h140;
  localparam logic [9:0] SC_BURST  = 10'h020;
  localparam logic [9:0] SC_LOAD_C = 10'h200;

  localparam int SRC_RESET = 1;

endpackage

// File: rtl/dmareg_stream_dec.sv
module dmareg_stream_dec
  import dmareg_pkg::*;
(
  input  logic [31:0] value_i,
  output logic        load_d_o,
  output logic        burst_o,
  output logic        load_c_o,
  output logic        bad_o
);
  logic [9:0] low;

  always_comb begin
    low      = value_i[9:0];
    load_d_o = |(low & SC_LOAD_D);
    burst_o  = load_d_o && |(low & SC_BURST);
    load_c_o = |(low & SC_LOAD_C);
    bad_o    = |value_i[31:10];
  end
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTR_W-1:0] set_i,
  input  logic              ack_wr_i,
  input  logic              mask_wr_i,
  input  logic [INTR_W-1:0] wdata_i,
  output logic [INTR_W-1:0] raw_o,
  output logic [INTR_W-1:0] mask_o,
  output logic [INTR_W-1:0] masked_o,
  output logic              irq_o
);
  logic [INTR_W-1:0] raw_nx, mask_nx;

  always_comb begin
    raw_nx = raw_o;
    if (ack_wr_i) raw_nx = raw_nx & ~wdata_i;
    raw_nx  = raw_nx | set_i;
    mask_nx = mask_wr_i ? wdata_i : mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_o    <= '0;
      mask_o   <= '0;
      masked_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      raw_o    <= raw_nx;
      mask_o   <= mask_nx;
      masked_o <= raw_nx & mask_nx;
      irq_o    <= |(raw_nx & mask_nx);
    end
  end

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_wr_i && set_i == '0) |=> ((raw_o & $past(wdata_i)) == '0));
  // R9
  event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int INTR_W = 4,
  parameter int SRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [5:0]        wreg_i,
  input  logic [31:0]       wdata_i,
  input  logic [5:0]        rreg_i,
  input  logic [INTR_W-1:0] eng_intr_i,
  input  logic              eng_eol_i,
  input  logic              eng_src_vld_i,
  input  logic [SRC_W-1:0]  eng_src_i,
  output logic [31:0]       rval_o,
  output logic              cont_o,
  output logic              load_d_o,
  output logic              load_c_o,
  output logic              start_o,
  output logic              irq_o,
  output logic [31:0]       desc_ptr_o,
  output logic [31:0]       buf_ptr_o
);
  logic [31:0] data_q, saved_q, sbuf_q, grp_q, gdown_q;
  logic [1:0]  cfg_q;
  logic        cmd_q;
  logic [9:0]  strm_q;
  ch_state_e   state_q;
  logic        eol_q, err_cmd_q, err_strm_q;
  logic [SRC_W-1:0] src_q;

  logic wr_cfg, wr_cmd, wr_strm, wr_stat, wr_ack, wr_mask;
  logic d_load_d, d_burst, d_load_c, d_bad, start_ok;
  logic [INTR_W-1:0] raw, mask, masked;

  assign wr_cfg  = wr_i && (wreg_i == RI_CFG);
  assign wr_cmd  = wr_i && (wreg_i == RI_CMD);
  assign wr_strm = wr_i && (wreg_i == RI_STREAM);
  assign wr_stat = wr_i && (wreg_i == RI_STAT);
  assign wr_ack  = wr_i && (wreg_i == RI_ACK);
  assign wr_mask = wr_i && (wreg_i == RI_MASK);

  dmareg_stream_dec u_dec (
    .value_i (wdata_i),
    .load_d_o(d_load_d),
    .burst_o (d_burst),
    .load_c_o(d_load_c),
    .bad_o   (d_bad)
  );

  assign start_ok = wr_strm && d_burst && cfg_q[0] && !cfg_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; saved_q <= '0; sbuf_q <= '0; grp_q <= '0; gdown_q <= '0;
      cfg_q <= '0; cmd_q <= 1'b0; strm_q <= '0;
      state_q <= ST_RST; eol_q <= 1'b0; src_q <= SRC_W'(SRC_RESET);
      err_cmd_q <= 1'b0; err_strm_q <= 1'b0;
      cont_o <= 1'b0; load_d_o <= 1'b0; load_c_o <= 1'b0; start_o <= 1'b0;
    end else begin
      if (wr_i) begin
        case (wreg_i)
          RI_DATA:   data_q  <= wdata_i;
          RI_SAVED:  saved_q <= wdata_i;
          RI_SBUF:   sbuf_q  <= wdata_i;
          RI_GROUP:  grp_q   <= wdata_i;
          RI_GDOWN:  gdown_q <= wdata_i;
          RI_CFG:    cfg_q   <= wdata_i[1:0];
          RI_CMD:    cmd_q   <= wdata_i[0];
          RI_STREAM: strm_q  <= wdata_i[9:0];
          default: ;
        endcase
      end
      if (wr_cfg) begin
        if (wdata_i[1])  state_q <= ST_STOP;
        if (!wdata_i[0]) state_q <= ST_RST;
      end else if (start_ok) begin
        state_q <= ST_RUN;
      end
      if (start_ok)       eol_q <= 1'b0;
      else if (eng_eol_i) eol_q <= 1'b1;
      if (eng_src_vld_i) src_q <= eng_src_i;
      if (wr_stat) begin
        err_cmd_q  <= 1'b0;
        err_strm_q <= 1'b0;
      end else begin
        if (wr_cmd && |wdata_i[31:1]) err_cmd_q  <= 1'b1;
        if (wr_strm && d_bad)         err_strm_q <= 1'b1;
      end
      cont_o   <= wr_cmd && wdata_i[0] && (state_q == ST_RUN);
      load_d_o <= wr_strm && d_load_d;
      load_c_o <= wr_strm && d_load_c;
      start_o  <= start_ok;
    end
  end

  dmareg_irq #(.INTR_W(INTR_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_i    (eng_intr_i),
    .ack_wr_i (wr_ack),
    .mask_wr_i(wr_mask),
    .wdata_i  (wdata_i[INTR_W-1:0]),
    .raw_o    (raw),
    .mask_o   (mask),
    .masked_o (masked),
    .irq_o    (irq_o)
  );

  assign desc_ptr_o = saved_q;
  assign buf_ptr_o  = sbuf_q;

  always_comb begin
    rval_o = '0;
    case (rreg_i)
      RI_DATA:   rval_o = data_q;
      RI_SAVED:  rval_o = saved_q;
      RI_SBUF:   rval_o = sbuf_q;
      RI_GROUP:  rval_o = grp_q;
      RI_GDOWN:  rval_o = gdown_q;
      RI_CMD:    rval_o[0] = cmd_q;
      RI_CFG:    rval_o[1:0] = cfg_q;
      RI_STAT: begin
        rval_o[2:0]         = state_q;
        rval_o[5]           = eol_q;
        rval_o[8 +: SRC_W]  = src_q;
        rval_o[30]          = err_strm_q;
        rval_o[31]          = err_cmd_q;
      end
      RI_MASK:   rval_o[INTR_W-1:0] = mask;
      RI_RAW:    rval_o[INTR_W-1:0] = raw;
      RI_MASKED: rval_o[INTR_W-1:0] = masked;
      RI_STREAM: rval_o[9:0] = strm_q;
      default:   rval_o = '0;
    endcase
  end

  // R8
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);
  // R4
  cfg_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wdata_i[0]) |=> (state_q == ST_RST));
  // R5
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (state_q == ST_RUN && !eol_q));
  // R7
  cont_running_chk: assert property (@(posedge clk) disable iff (rst)
    cont_o |-> (state_q == ST_RUN));
  // R7
  cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && |wdata_i[31:1]) |=> err_cmd_q);
  // R6
  strm_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_strm && |wdata_i[31:10]) |=> err_strm_q);
endmodule

// File: rtl/dmareg_unit.sv
module dmareg_unit #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 14,
  parameter int INTR_W = 4,
  parameter int SRC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CH*INTR_W-1:0] eng_intr_set,
  input  logic [NUM_CH-1:0]        eng_eol,
  input  logic [NUM_CH-1:0]        eng_src_vld,
  input  logic [NUM_CH*SRC_W-1:0]  eng_src,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH-1:0]        cont_req,
  output logic [NUM_CH-1:0]        load_data_req,
  output logic [NUM_CH-1:0]        load_ctx_req,
  output logic [NUM_CH-1:0]        start_req,
  output logic [NUM_CH*32-1:0]     desc_ptr,
  output logic [NUM_CH*32-1:0]     buf_ptr
);
  localparam int CH_W = ADDR_W - 13;

  logic [CH_W-1:0] ch_sel;
  logic [5:0]      reg_sel;
  logic [31:0]     rvals [NUM_CH];
  logic [31:0]     rd_mux;

  assign ch_sel  = bus_addr[ADDR_W-1:13];
  assign reg_sel = bus_addr[7:2];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmareg_chan #(.INTR_W(INTR_W), .SRC_W(SRC_W)) u_chan (
      .clk          (clk),
      .rst          (rst),
      .wr_i         (bus_wr && (ch_sel == CH_W'(g))),
      .wreg_i       (reg_sel),
      .wdata_i      (bus_wdata),
      .rreg_i       (reg_sel),
      .eng_intr_i   (eng_intr_set[g*INTR_W +: INTR_W]),
      .eng_eol_i    (eng_eol[g]),
      .eng_src_vld_i(eng_src_vld[g]),
      .eng_src_i    (eng_src[g*SRC_W +: SRC_W]),
      .rval_o       (rvals[g]),
      .cont_o       (cont_req[g]),
      .load_d_o     (load_data_req[g]),
      .load_c_o     (load_ctx_req[g]),
      .start_o      (start_req[g]),
      .irq_o        (irq[g]),
      .desc_ptr_o   (desc_ptr[g*32 +: 32]),
      .buf_ptr_o    (buf_ptr[g*32 +: 32])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_sel == CH_W'(i)) rd_mux = rvals[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/test_dmareg_unit.sv
module test_dmareg_unit;
  localparam int NCH = 3;
  localparam int AW  = 15;
  localparam int IW  = 4;
  localparam int SW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NCH*IW-1:0] eng_intr_set = '0;
  logic [NCH-1:0] eng_eol = '0, eng_src_vld = '0;
  logic [NCH*SW-1:0] eng_src = '0;
  logic [NCH-1:0] irq, cont_req, load_data_req, load_ctx_req, start_req;
  logic [NCH*32-1:0] desc_ptr, buf_ptr;

  always #2.5 clk = ~clk;

  dmareg_unit #(.NUM_CH(NCH), .ADDR_W(AW), .INTR_W(IW), .SRC_W(SW)) i_dmareg_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_intr_set(eng_intr_set), .eng_eol(eng_eol), .eng_src_vld(eng_src_vld),
    .eng_src(eng_src), .irq(irq), .cont_req(cont_req), .load_data_req(load_data_req),
    .load_ctx_req(load_ctx_req), .start_req(start_req), .desc_ptr(desc_ptr), .buf_ptr(buf_ptr));

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  item_t cur;
  int errors = 0, checks = 0;
  logic [3:0] cap;  // {start, load_c, load_d, cont} for channel 0
  logic [NCH-1:0] cap_irq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int ch, input int off);
    return AW'((ch << 13) | off);
  endfunction

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    bus_addr = adr(ch, off); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    cap = {start_req[0], load_ctx_req[0], load_data_req[0], cont_req[0]};
    cap_irq = irq;
  endtask

  task automatic rd(input int ch, input int off, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_addr = adr(ch, off); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (sb.size() == 0) chk(1'b0, "R13 unexpected read data", bus_rdata, 32'h0);
      else begin
        cur = sb.pop_front();
        chk(bus_rdata === cur.exp, cur.tag, bus_rdata, cur.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == '0, "R1 irq low", 32'(irq), 0);
    chk({cont_req, load_data_req, load_ctx_req, start_req} == '0, "R1 pulses low", 0, 0);
    rd(0, 'h88, 32'h101, "R1 status reset");
    rd(1, 'h8C, 32'h0, "R1 mask reset");
    rd(2, 'h58, 32'h0, "R1 pointer reset");

    // R2 pointers
    wr(0, 'h58, 32'h1234_5670);
    wr(0, 'h5C, 32'hCAFE_0010);
    wr(0, 'h7C, 32'hDEAD_BEEF);
    wr(0, 'h00, 32'h0BAD_F00D);
    rd(0, 'h58, 32'h1234_5670, "R2 saved ptr");
    rd(0, 'h5C, 32'hCAFE_0010, "R2 buf ptr");
    rd(0, 'h7C, 32'hDEAD_BEEF, "R2 group-down");
    rd(0, 'h00, 32'h0BAD_F00D, "R2 data desc");
    chk(desc_ptr[31:0] == 32'h1234_5670, "R2 desc_ptr out", desc_ptr[31:0], 32'h1234_5670);
    chk(buf_ptr[31:0] == 32'hCAFE_0010, "R2 buf_ptr out", buf_ptr[31:0], 32'hCAFE_0010);

    // R3 decode
    wr(0, 'h100 | 'h60, 32'h0000_A5A5);
    wr(1, 'h60, 32'h77);
    wr(3, 'h60, 32'h99);
    rd(0, 'h60, 32'h0000_A5A5, "R3 alias bits 12:8");
    rd(1, 'h60, 32'h77, "R3 channel 1 isolated");
    rd(2, 'h60, 32'h0, "R3 unmapped write no effect");
    rd(3, 'h60, 32'h0, "R3 unmapped read zero");

    // R4 / R5 start
    wr(0, 'h84, 32'h1);
    rd(0, 'h88, 32'h101, "R4 enable keeps state");
    wr(0, 'h9C, 32'h160);
    chk(cap == 4'b1010, "R5 load+start pulses", 32'(cap), 32'hA);
    rd(0, 'h88, 32'h104, "R5 running");
    // R11 eol
    eng_eol[0] = 1'b1; @(negedge clk); eng_eol[0] = 1'b0;
    rd(0, 'h88, 32'h124, "R11 eol set");
    wr(0, 'h9C, 32'h160);
    rd(0, 'h88, 32'h104, "R11 eol cleared by start");
    // R7 continue
    wr(0, 'h80, 32'h1);
    chk(cap == 4'b0001, "R7 continue pulse", 32'(cap), 32'h1);
    @(negedge clk);
    chk(cont_req[0] == 1'b0, "R13 pulse one cycle", 32'(cont_req), 0);
    wr(0, 'h80, 32'h3);
    chk(cap == 4'b0001, "R7 continue with bad bits", 32'(cap), 32'h1);
    rd(0, 'h88, 32'h8000_0104, "R7 cmd error sticky");
    wr(0, 'h88, 32'h0);
    rd(0, 'h88, 32'h104, "R7 status write clears");
    // R5 context load
    wr(0, 'h9C, 32'h200);
    chk(cap == 4'b0100, "R5 context load only", 32'(cap), 32'h4);
    // R6 stream error
    wr(0, 'h9C, 32'h400);
    chk(cap == 4'b0000, "R6 no pulses for high bits", 32'(cap), 0);
    rd(0, 'h88, 32'h4000_0104, "R6 stream error sticky");
    wr(0, 'h88, 32'h0);
    // R4 stop / reset
    wr(0, 'h84, 32'h3);
    rd(0, 'h88, 32'h102, "R4 stopped");
    wr(0, 'h80, 32'h1);
    chk(cap == 4'b0000, "R7 no continue when stopped", 32'(cap), 0);
    wr(0, 'h84, 32'h1);
    rd(0, 'h88, 32'h102, "R4 enable alone keeps stopped");
    wr(0, 'h84, 32'h0);
    rd(0, 'h88, 32'h101, "R4 disable resets");
    wr(0, 'h9C, 32'h160);
    chk(cap == 4'b0010, "R5 start ignored when disabled", 32'(cap), 32'h2);
    rd(0, 'h88, 32'h101, "R5 state kept when disabled");

    // R9 / R10 interrupts
    wr(0, 'h8C, 32'h4);
    eng_intr_set[3:0] = 4'h5; @(negedge clk); eng_intr_set[3:0] = 4'h0;
    chk(irq == 3'b001, "R10 irq raised", 32'(irq), 1);
    rd(0, 'h94, 32'h5, "R9 raw set");
    rd(0, 'h98, 32'h4, "R10 masked");
    wr(0, 'h90, 32'h4);
    chk(cap_irq == 3'b000, "R10 irq drops after ack", 32'(cap_irq), 0);
    rd(0, 'h94, 32'h1, "R9 ack clears bit");
    rd(0, 'h98, 32'h0, "R10 masked after ack");
    rd(0, 'h90, 32'h0, "R9 ack reads zero");
    eng_intr_set[3:0] = 4'h1;
    wr(0, 'h90, 32'h1);
    eng_intr_set[3:0] = 4'h0;
    rd(0, 'h94, 32'h1, "R9 event beats ack");
    wr(0, 'h90, 32'h1);
    rd(0, 'h94, 32'h0, "R9 ack alone clears");
    wr(0, 'h8C, 32'h1);
    eng_intr_set[7:4] = 4'h1; @(negedge clk); eng_intr_set[7:4] = 4'h0;
    chk(irq == 3'b000, "R10 neighbour masked off", 32'(irq), 0);

    // R12 source
    eng_src[7:0] = 8'h5A; eng_src_vld[0] = 1'b1; @(negedge clk); eng_src_vld[0] = 1'b0;
    eng_src[7:0] = 8'h33; @(negedge clk);
    rd(0, 'h88, 32'h5A01, "R12 source loaded only on strobe");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R13 all reads answered", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule